// File: doc/BRIEF.md
# Machine-Mode Cycle, Retire and Time Counter CSRs

This block is the counter slice of a machine-mode CSR file. It holds a 64-bit cycle counter and a 64-bit retired-instruction counter. Each is seen through the CSR space as a low word and a high word. It also gives a read-only view of a free-running microsecond timer that lives outside the block and arrives as a 64-bit input. A counter-inhibit register lets software freeze either counter on its own.

The core presents one CSR access per cycle: a valid strobe, a 12-bit address, an operation code and a write operand. The block returns the old value of the addressed register in that same cycle, with no wait state. Any write takes effect at the next rising clock edge. A separate strobe marks each retired instruction. The unprivileged aliases of the counters read the same state as the machine-mode names.

Top module: `perf_csr_unit`

## Requirements
- R1: The address map is: 0xB00/0xB80 mcycle low/high, 0xB02/0xB82 minstret low/high, 0x320 mcountinhibit. The read-only aliases are 0xC00/0xC80 for cycle, 0xC02/0xC82 for instret and 0xC01/0xC81 for time. Each alias returns the same word as its machine-mode counterpart.
- R2: At every rising edge, mcycle increments by one while mcountinhibit bit 0 is clear. It holds while that bit is set.
- R3: At a rising edge, minstret increments by exactly one when retire_i is high and mcountinhibit bit 2 is clear. In every other cycle it holds.
- R4: When the low word of a counter wraps from 0xFFFFFFFF to 0 by counting, the high word increments at that same edge.
- R5: A write to one word of a counter loads that word and replaces that word's increment for the cycle. The other word is unchanged, except that it keeps counting if it is the low word. A write to the low word produces no carry.
- R6: The time and timeh aliases (0xC01/0xC81) return time_i[31:0] and time_i[63:32] in the cycle of the access. Writes to any 0xCxx alias have no effect and do not raise csr_illegal_o.
- R7: Only bits 0 and 2 of mcountinhibit are writable. Bit 1 and bits 31:3 always read zero.
- R8: csr_op_i encodes the operation: 00 read only, 01 write operand, 10 set the operand's one bits, 11 clear the operand's one bits. A set or clear with an all-zero operand performs no write, so a running counter keeps counting.
- R9: csr_rdata_o is combinational and shows the register value from before that cycle's update. A write appears from the next cycle on.
- R10: An access with csr_valid_i high to an unimplemented address returns zero and raises csr_illegal_o in that cycle, and writes nothing. With csr_valid_i low, csr_rdata_o is zero and csr_illegal_o is low.
- R11: After reset, both counters and mcountinhibit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_valid_i | input | 1 | A CSR access is presented this cycle |
| csr_op_i | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write, set or clear operand |
| retire_i | input | 1 | One instruction retires this cycle |
| time_i | input | 64 | Microsecond time from the external timer |
| csr_rdata_o | output | 32 | Value of the addressed CSR before update |
| csr_illegal_o | output | 1 | Access to an unimplemented CSR address |

## Verification
The counter properties assume the core gives at most one access per cycle, and that retire_i is a single-level strobe worth one instruction. The time properties assume time_i is stable while its value is sampled. The stimulus drives every input on the falling edge and keeps it constant until the next falling edge. It freezes both counters through the inhibit register before it checks exact words, so that expected values do not depend on elapsed cycles. Running-counter checks count the rising edges between the inhibit release and each read.

// File: rtl/perf_csr_pkg.sv
package perf_csr_pkg;

  localparam int unsigned CSR_AW = 12;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_CY_LO,
    SRC_CY_HI,
    SRC_IR_LO,
    SRC_IR_HI,
    SRC_TM_LO,
    SRC_TM_HI,
    SRC_INH
  } csr_src_e;

  typedef struct packed {
    csr_src_e src;
    logic     writable;
    logic     hit;
  } csr_dec_t;

  localparam logic [CSR_AW-1:0] A_MCYCLE    = 12'hB00;
  localparam logic [CSR_AW-1:0] A_MCYCLEH   = 12'hB80;
  localparam logic [CSR_AW-1:0] A_MINSTRET  = 12'hB02;
  localparam logic [CSR_AW-1:0] A_MINSTRETH = 12'hB82;
  localparam logic [CSR_AW-1:0] A_CYCLE     = 12'hC00;
  localparam logic [CSR_AW-1:0] A_CYCLEH    = 12'hC80;
  localparam logic [CSR_AW-1:0] A_TIME      = 12'hC01;
  localparam logic [CSR_AW-1:0] A_TIMEH     = 12'hC81;
  localparam logic [CSR_AW-1:0] A_INSTRET   = 12'hC02;
  localparam logic [CSR_AW-1:0] A_INSTRETH  = 12'hC82;
  localparam logic [CSR_AW-1:0] A_INHIBIT   = 12'h320;

  // inhibit bit positions are architectural
  localparam int unsigned INH_CY_BIT = 0;
  localparam int unsigned INH_IR_BIT = 2;

endpackage

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
  import perf_csr_pkg::*;
(
  input  logic [CSR_AW-1:0] addr_i,
  output csr_dec_t          dec_o
);

  always_comb begin
    dec_o = '{src: SRC_NONE, writable: 1'b0, hit: 1'b0};
    unique case (addr_i)
      A_MCYCLE:    dec_o = '{src: SRC_CY_LO, writable: 1'b1, hit: 1'b1};
      A_MCYCLEH:   dec_o = '{src: SRC_CY_HI, writable: 1'b1, hit: 1'b1};
      A_MINSTRET:  dec_o = '{src: SRC_IR_LO, writable: 1'b1, hit: 1'b1};
      A_MINSTRETH: dec_o = '{src: SRC_IR_HI, writable: 1'b1, hit: 1'b1};
      A_INHIBIT:   dec_o = '{src: SRC_INH,   writable: 1'b1, hit: 1'b1};
      A_CYCLE:     dec_o = '{src: SRC_CY_LO, writable: 1'b0, hit: 1'b1};
      A_CYCLEH:    dec_o = '{src: SRC_CY_HI, writable: 1'b0, hit: 1'b1};
      A_INSTRET:   dec_o = '{src: SRC_IR_LO, writable: 1'b0, hit: 1'b1};
      A_INSTRETH:  dec_o = '{src: SRC_IR_HI, writable: 1'b0, hit: 1'b1};
      A_TIME:      dec_o = '{src: SRC_TM_LO, writable: 1'b0, hit: 1'b1};
      A_TIMEH:     dec_o = '{src: SRC_TM_HI, writable: 1'b0, hit: 1'b1};
      default:     dec_o = '{src: SRC_NONE,  writable: 1'b0, hit: 1'b0};
    endcase
  end

endmodule

// File: rtl/perf_csr_modify.sv
module perf_csr_modify
  import perf_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] operand_i,
  output logic [XLEN-1:0] new_o,
  output logic            wr_req_o
);

  csr_op_e op;
  logic    operand_nz;

  assign op         = csr_op_e'(op_i);
  assign operand_nz = |operand_i;

  always_comb begin
    new_o    = old_i;
    wr_req_o = 1'b0;
    unique case (op)
      OP_WRITE: begin
        new_o    = operand_i;
        wr_req_o = 1'b1;
      end
      OP_SET: begin
        new_o    = old_i | operand_i;
        wr_req_o = operand_nz;
      end
      OP_CLEAR: begin
        new_o    = old_i & ~operand_i;
        wr_req_o = operand_nz;
      end
      default: begin
        new_o    = old_i;
        wr_req_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/perf_counter_split.sv
module perf_counter_split #(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [2*XLEN-1:0] value_o
);

  logic [XLEN-1:0] lo_q, hi_q;
  logic            carry;

  // a low-word write suppresses the carry for this cycle
  assign carry = inc_i & ~wr_lo_i & (&lo_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo_i)    lo_q <= wdata_i;
      else if (inc_i) lo_q <= lo_q + 1'b1;
      if (wr_hi_i)    hi_q <= wdata_i;
      else if (carry) hi_q <= hi_q + 1'b1;
    end
  end

  assign value_o = {hi_q, lo_q};

endmodule

// File: rtl/perf_csr_unit.sv
module perf_csr_unit
  import perf_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_valid_i,
  input  logic [1:0]          csr_op_i,
  input  logic [CSR_AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  input  logic                retire_i,
  input  logic [2*XLEN-1:0]   time_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic                csr_illegal_o
);

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned CY_IDX  = 0;
  localparam int unsigned IR_IDX  = 1;

  csr_dec_t          dec;
  logic [XLEN-1:0]   rd_raw;
  logic [XLEN-1:0]   wr_val;
  logic              wr_req;
  logic              wr_en;
  logic              inh_cy_q, inh_ir_q;
  logic [XLEN-1:0]   inh_word;

  logic [2*XLEN-1:0] cnt_val [NUM_CNT];
  logic              cnt_inc [NUM_CNT];
  logic              cnt_wlo [NUM_CNT];
  logic              cnt_whi [NUM_CNT];

  logic [2*XLEN-1:0] cycle_val, instret_val;
  logic              cycle_wr, instret_wr;

  perf_csr_decode i_decode (
    .addr_i (csr_addr_i),
    .dec_o  (dec)
  );

  always_comb begin
    inh_word             = '0;
    inh_word[INH_CY_BIT] = inh_cy_q;
    inh_word[INH_IR_BIT] = inh_ir_q;
  end

  always_comb begin
    unique case (dec.src)
      SRC_CY_LO: rd_raw = cnt_val[CY_IDX][XLEN-1:0];
      SRC_CY_HI: rd_raw = cnt_val[CY_IDX][2*XLEN-1:XLEN];
      SRC_IR_LO: rd_raw = cnt_val[IR_IDX][XLEN-1:0];
      SRC_IR_HI: rd_raw = cnt_val[IR_IDX][2*XLEN-1:XLEN];
      SRC_TM_LO: rd_raw = time_i[XLEN-1:0];
      SRC_TM_HI: rd_raw = time_i[2*XLEN-1:XLEN];
      SRC_INH:   rd_raw = inh_word;
      default:   rd_raw = '0;
    endcase
  end

  assign csr_rdata_o   = csr_valid_i ? rd_raw : '0;
  assign csr_illegal_o = csr_valid_i & ~dec.hit;

  perf_csr_modify #(.XLEN(XLEN)) i_modify (
    .op_i      (csr_op_i),
    .old_i     (rd_raw),
    .operand_i (csr_wdata_i),
    .new_o     (wr_val),
    .wr_req_o  (wr_req)
  );

  assign wr_en = csr_valid_i & dec.hit & dec.writable & wr_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_cy_q <= 1'b0;
      inh_ir_q <= 1'b0;
    end else if (wr_en && dec.src == SRC_INH) begin
      inh_cy_q <= wr_val[INH_CY_BIT];
      inh_ir_q <= wr_val[INH_IR_BIT];
    end
  end

  assign cnt_inc[CY_IDX] = ~inh_cy_q;
  assign cnt_inc[IR_IDX] = retire_i & ~inh_ir_q;
  assign cnt_wlo[CY_IDX] = wr_en & (dec.src == SRC_CY_LO);
  assign cnt_whi[CY_IDX] = wr_en & (dec.src == SRC_CY_HI);
  assign cnt_wlo[IR_IDX] = wr_en & (dec.src == SRC_IR_LO);
  assign cnt_whi[IR_IDX] = wr_en & (dec.src == SRC_IR_HI);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    perf_counter_split #(.XLEN(XLEN)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (cnt_inc[g]),
      .wr_lo_i (cnt_wlo[g]),
      .wr_hi_i (cnt_whi[g]),
      .wdata_i (wr_val),
      .value_o (cnt_val[g])
    );
  end

  assign cycle_val   = cnt_val[CY_IDX];
  assign instret_val = cnt_val[IR_IDX];
  assign cycle_wr    = cnt_wlo[CY_IDX] | cnt_whi[CY_IDX];
  assign instret_wr  = cnt_wlo[IR_IDX] | cnt_whi[IR_IDX];

endmodule

// File: rtl/perf_csr_checker.sv
module perf_csr_checker
  import perf_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                csr_valid_i,
  input logic [CSR_AW-1:0]   csr_addr_i,
  input logic                retire_i,
  input logic [2*XLEN-1:0]   time_i,
  input logic [XLEN-1:0]     csr_rdata_o,
  input logic                csr_illegal_o,
  input logic [2*XLEN-1:0]   cycle_val,
  input logic [2*XLEN-1:0]   instret_val,
  input logic                cycle_wr,
  input logic                instret_wr,
  input logic                inh_cy_q,
  input logic                inh_ir_q
);

  localparam logic [2*XLEN-1:0] ONE = 1;

  AST_CYCLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh_cy_q && !cycle_wr) |=> cycle_val == $past(cycle_val) + ONE); // R2

  AST_CYCLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_cy_q && !cycle_wr) |=> $stable(cycle_val)); // R2

  AST_INSTRET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !inh_ir_q && !instret_wr) |=> instret_val == $past(instret_val) + ONE); // R3

  AST_INSTRET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!retire_i || inh_ir_q) && !instret_wr) |=> $stable(instret_val)); // R3

  AST_TIME_LO_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i == A_TIME) |-> csr_rdata_o == time_i[XLEN-1:0]); // R6

  AST_TIME_HI_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i == A_TIMEH) |-> csr_rdata_o == time_i[2*XLEN-1:XLEN]); // R6

  AST_INHIBIT_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_addr_i == A_INHIBIT) |-> (csr_rdata_o[XLEN-1:3] == '0 && !csr_rdata_o[1])); // R7

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |-> (!csr_illegal_o && csr_rdata_o == '0)); // R10

endmodule

bind perf_csr_unit perf_csr_checker #(.XLEN(XLEN)) i_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_valid_i   (csr_valid_i),
  .csr_addr_i    (csr_addr_i),
  .retire_i      (retire_i),
  .time_i        (time_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .cycle_val     (cycle_val),
  .instret_val   (instret_val),
  .cycle_wr      (cycle_wr),
  .instret_wr    (instret_wr),
  .inh_cy_q      (inh_cy_q),
  .inh_ir_q      (inh_ir_q)
);

// File: tb/test_perf_csr_unit.sv
module test_perf_csr_unit;

  localparam logic [1:0] RD = 2'b00;
  localparam logic [1:0] WR = 2'b01;
  localparam logic [1:0] ST = 2'b10;
  localparam logic [1:0] CL = 2'b11;
  localparam logic [63:0] TIME_VAL = 64'h0000_00AB_1234_5678;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        ret;
    logic        chk;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{WR, 12'h320, 32'h0000_0005, 1'b0, 1'b1, 32'h0000_0000, 1'b0}, // R7 freeze both, old 0
    '{RD, 12'h320, 32'h0,         1'b0, 1'b1, 32'h0000_0005, 1'b0}, // R9 write visible next cycle
    '{WR, 12'h320, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_0005, 1'b0}, // R7
    '{RD, 12'h320, 32'h0,         1'b0, 1'b1, 32'h0000_0005, 1'b0}, // R7 only bits 0,2
    '{WR, 12'hB00, 32'h1111_1111, 1'b0, 1'b0, 32'h0,         1'b0}, // R5
    '{WR, 12'hB80, 32'h2222_2222, 1'b0, 1'b0, 32'h0,         1'b0}, // R5
    '{RD, 12'hB00, 32'h0,         1'b0, 1'b1, 32'h1111_1111, 1'b0}, // R5 low kept
    '{RD, 12'hC80, 32'h0,         1'b0, 1'b1, 32'h2222_2222, 1'b0}, // R1 alias high
    '{ST, 12'hB00, 32'h0000_00F0, 1'b0, 1'b1, 32'h1111_1111, 1'b0}, // R8 set, old value back
    '{RD, 12'hC00, 32'h0,         1'b0, 1'b1, 32'h1111_11F1, 1'b0}, // R8 set result via alias
    '{CL, 12'hB00, 32'h0000_0011, 1'b0, 1'b1, 32'h1111_11F1, 1'b0}, // R8 clear
    '{RD, 12'hB00, 32'h0,         1'b0, 1'b1, 32'h1111_11E0, 1'b0}, // R8 clear result
    '{WR, 12'hC01, 32'h0000_DEAD, 1'b0, 1'b1, 32'h1234_5678, 1'b0}, // R6 time low, write ignored
    '{RD, 12'hC81, 32'h0,         1'b0, 1'b1, 32'h0000_00AB, 1'b0}, // R6 time high
    '{WR, 12'hC00, 32'h0,         1'b0, 1'b1, 32'h1111_11E0, 1'b0}, // R6 alias write
    '{RD, 12'hB00, 32'h0,         1'b0, 1'b1, 32'h1111_11E0, 1'b0}, // R6 alias write had no effect
    '{WR, 12'hB02, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h0,         1'b0}, // R5
    '{WR, 12'hB82, 32'h0000_0007, 1'b1, 1'b0, 32'h0,         1'b0}, // R3 retire while frozen
    '{RD, 12'hC02, 32'h0,         1'b1, 1'b1, 32'hFFFF_FFFE, 1'b0}, // R1 R3 alias, frozen
    '{RD, 12'hB02, 32'h0,         1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0}, // R3 still frozen
    '{RD, 12'h123, 32'h0,         1'b0, 1'b1, 32'h0000_0000, 1'b1}, // R10 unimplemented
    '{WR, 12'hB01, 32'h0000_0055, 1'b0, 1'b1, 32'h0000_0000, 1'b1}  // R10 unimplemented write
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = RD;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        retire = 1'b0;
  logic [63:0] time_in = TIME_VAL;
  logic [31:0] rdata;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_csr_unit i_perf_csr_unit (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_valid_i   (valid),
    .csr_op_i      (op),
    .csr_addr_i    (addr),
    .csr_wdata_i   (wdata),
    .retire_i      (retire),
    .time_i        (time_in),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample before the next rising edge
  task automatic acc(input logic v, input logic [1:0] o, input logic [11:0] a,
                     input logic [31:0] d, input logic r,
                     output logic [31:0] rd, output logic il);
    @(negedge clk);
    valid  = v;
    op     = o;
    addr   = a;
    wdata  = d;
    retire = r;
    #2;
    rd = rdata;
    il = illegal;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        il;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    acc(1'b1, RD, 12'hB80, 32'h0, 1'b0, rd, il); check("R11 mcycleh", rd, 32'h0);
    check("R11 illegal", {31'b0, il}, 32'h0);
    acc(1'b1, RD, 12'hB02, 32'h0, 1'b0, rd, il); check("R11 minstret", rd, 32'h0);
    acc(1'b1, RD, 12'h320, 32'h0, 1'b0, rd, il); check("R11 inhibit", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      acc(1'b1, VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].ret, rd, il);
      if (VECS[i].chk) begin
        check($sformatf("vec%0d rdata", i), rd, VECS[i].exp);
        check($sformatf("vec%0d illegal", i), {31'b0, il}, {31'b0, VECS[i].ill});
      end
    end

    // R10 idle outputs
    acc(1'b0, RD, 12'hB00, 32'h0, 1'b0, rd, il);
    check("R10 idle rdata", rd, 32'h0);
    check("R10 idle illegal", {31'b0, il}, 32'h0);

    // R3 R4: release instret, three retires carry into high word
    acc(1'b1, WR, 12'h320, 32'h0000_0001, 1'b0, rd, il); check("R7 inhibit old", rd, 32'h5);
    repeat (3) acc(1'b0, RD, 12'h0, 32'h0, 1'b1, rd, il);
    acc(1'b1, RD, 12'hB02, 32'h0, 1'b0, rd, il); check("R3 minstret low", rd, 32'h1);
    acc(1'b1, RD, 12'hB82, 32'h0, 1'b0, rd, il); check("R4 minstret carry", rd, 32'h8);

    // R2 R4: load cycle near wrap, then release it
    acc(1'b1, WR, 12'hB00, 32'hFFFF_FFFD, 1'b0, rd, il);
    acc(1'b1, WR, 12'hB80, 32'h0, 1'b0, rd, il);
    acc(1'b1, WR, 12'h320, 32'h0, 1'b0, rd, il);
    acc(1'b1, RD, 12'hB00, 32'h0, 1'b0, rd, il); check("R2 cycle t0", rd, 32'hFFFF_FFFD);
    acc(1'b0, RD, 12'h0, 32'h0, 1'b0, rd, il);
    acc(1'b1, RD, 12'hB00, 32'h0, 1'b0, rd, il); check("R2 cycle t2", rd, 32'hFFFF_FFFF);
    acc(1'b1, RD, 12'hB80, 32'h0, 1'b0, rd, il); check("R4 cycle carry", rd, 32'h1);
    acc(1'b1, RD, 12'hB00, 32'h0, 1'b0, rd, il); check("R2 cycle t4", rd, 32'h1);

    // R8 zero-operand set/clear does not disturb counting
    acc(1'b1, ST, 12'hB00, 32'h0, 1'b0, rd, il); check("R8 set zero old", rd, 32'h2);
    acc(1'b1, CL, 12'hB00, 32'h0, 1'b0, rd, il); check("R8 set zero no write", rd, 32'h3);
    acc(1'b1, RD, 12'hB00, 32'h0, 1'b0, rd, il); check("R8 clear zero no write", rd, 32'h4);

    // R5 low-word write wins, high word kept
    acc(1'b1, WR, 12'hB00, 32'h0000_0100, 1'b0, rd, il);
    acc(1'b1, RD, 12'hB00, 32'h0, 1'b0, rd, il); check("R5 cycle low loaded", rd, 32'h100);
    acc(1'b1, RD, 12'hB80, 32'h0, 1'b0, rd, il); check("R5 cycle high kept", rd, 32'h1);

    // R9 R3 retire during a read shows the old value first
    acc(1'b1, RD, 12'hB02, 32'h0, 1'b1, rd, il); check("R9 instret old", rd, 32'h1);
    acc(1'b1, RD, 12'hB02, 32'h0, 1'b0, rd, il); check("R3 instret plus one", rd, 32'h2);

    acc(1'b0, RD, 12'h0, 32'h0, 1'b0, rd, il);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule